// File: doc/BRIEF.md
# Printer Port Register Block

This block sits on a byte-wide host bus and presents the three registers of a classic printer port: an output byte latch, a status byte and a control byte. The host writes a byte to the data register and then toggles bits in the control register. Those control edges decide when the latched byte is handed to a peripheral-side byte sink, and when an interrupt is posted.

No real printer is attached. The busy and acknowledge status bits are produced inside the block by a fixed sequence. Each host status read moves that sequence one step, so a polling driver sees the handshake it expects. The interrupt is a level signal and stays pending until the host reads status.

The host presents a 3-bit register offset, a read strobe and a write strobe. The host does not assert both strobes in the same cycle. Read data is combinational from the current register state, and every state change takes effect on the clock edge that ends the access.

Top module: `printer_port_regs`

## Requirements
- R1: After reset the block is in its initial state. Status reads 0xD9, control reads 0xCC and data reads 0xFF. `irq` is low and `dev_byte_valid` is low.
- R2: Offsets 0, 1 and 2 select data, status and control. Reads of offsets 3 to 7 return 0xFF. Writes to offset 1 and to offsets 3 to 7 change no register.
- R3: A write to control stores the written byte with bits 7 and 6 forced to 1, and a control read returns the stored value.
- R4: A control write with bit 2 (init) at 0 loads status with 0xD8, which has busy-inverted (bit 7), ack (bit 6), online (bit 4) and error-inverted (bit 3) set. Such a write emits no byte and posts no interrupt.
- R5: A control write with bit 2 at 1, bit 3 (select) at 1 and bit 0 (strobe) at 1 clears status bit 7. In that same write cycle the data register value appears on `dev_byte` with a one-cycle `dev_byte_valid` pulse, but only if the stored control bit 0 was 0 before the write.
- R6: A control write with bit 2 at 1, bit 3 at 1 and bit 0 at 0 makes the interrupt pending if the stored control bit 4 (interrupt enable) was 1 before the write. `irq` is high from the clock edge that ends that write.
- R7: A status read returns the current status and clears the pending interrupt. `irq` is low from the edge that ends the read.
- R8: After a status read that finds bit 7 at 0 and stored control bit 0 at 0, the status changes. If bit 6 was 1, it is cleared. If bit 6 was 0, both bit 6 and bit 7 are set.
- R9: A data read returns the byte captured from `dev_din` at the previous clock edge when control bit 5 (direction) is 1, and the last written data byte otherwise.
- R10: A control write with bit 2 at 1 and bit 3 at 0 leaves status unchanged, emits no byte and posts no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 3 | Register offset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current offset |
| dev_byte_valid | output | 1 | One-cycle pulse that hands a byte to the sink |
| dev_byte | output | 8 | Byte handed to the sink |
| dev_din | input | 8 | Peripheral input byte, captured every clock |
| irq | output | 1 | Level interrupt, high while an interrupt is pending |

## Verification
The strobe bit is driven through low-to-high and high-to-high control writes. This separates an edge that emits a byte from a repeated level that must not. Control writes with init low, with select low and with interrupt enable toggled between successive writes show that the previously stored control byte, not the new one, gates the interrupt and the emission. Repeated status reads walk the busy/ack sequence through every state, 0x58 to 0x18 to 0xD8 and then holding. The data register is read in both directions with two different input bytes, and writes to unmapped and read-only offsets are followed by reads that would expose any change.

// File: rtl/ppr_pkg.sv
package ppr_pkg;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] OFF_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] OFF_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] OFF_CTRL = 3'd2;

  // control bit positions
  localparam int C_STB  = 0;
  localparam int C_ALF  = 1;
  localparam int C_INIT = 2;
  localparam int C_SEL  = 3;
  localparam int C_IEN  = 4;
  localparam int C_DIR  = 5;

  // status bit positions
  localparam int S_TMO  = 0;
  localparam int S_ERRN = 3;
  localparam int S_ONL  = 4;
  localparam int S_PAP  = 5;
  localparam int S_ACK  = 6;
  localparam int S_BSYN = 7;

  localparam logic [REG_W-1:0] CTRL_FIXED = 8'hC0;
  localparam logic [REG_W-1:0] STAT_INIT  = (8'h1 << S_BSYN) | (8'h1 << S_ACK) |
                                            (8'h1 << S_ONL)  | (8'h1 << S_ERRN);
  localparam logic [REG_W-1:0] STAT_RST   = STAT_INIT | (8'h1 << S_TMO);
  localparam logic [REG_W-1:0] CTRL_RST   = CTRL_FIXED | (8'h1 << C_SEL) | (8'h1 << C_INIT);
  localparam logic [REG_W-1:0] DATA_RST   = '1;
  localparam logic [REG_W-1:0] OPEN_READ  = '1;

  typedef struct packed {
    logic wr_data;
    logic wr_ctrl;
    logic rd_stat;
  } acc_t;

  typedef struct packed {
    logic init_load;
    logic busy_clr;
    logic emit;
    logic post_irq;
  } ctrl_ev_t;
endpackage

// File: rtl/ppr_decode.sv
module ppr_decode
  import ppr_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output acc_t              acc
);
  always_comb begin
    acc         = '0;
    acc.wr_data = wr && (addr == OFF_DATA);
    acc.wr_ctrl = wr && (addr == OFF_CTRL);
    acc.rd_stat = rd && (addr == OFF_STAT);
  end
endmodule

// File: rtl/ppr_ctrl_path.sv
module ppr_ctrl_path
  import ppr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  acc_t             acc,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] ctrl_q,
  output logic [REG_W-1:0] dout_q,
  output ctrl_ev_t         ev
);
  logic [REG_W-1:0] ctrl_d, dout_d;
  logic             armed;

  // event decode against the control byte stored before this write
  always_comb begin
    ev           = '0;
    armed        = acc.wr_ctrl && wdata[C_INIT] && wdata[C_SEL];
    ev.init_load = acc.wr_ctrl && !wdata[C_INIT];
    ev.busy_clr  = armed && wdata[C_STB];
    ev.emit      = armed && wdata[C_STB] && !ctrl_q[C_STB];
    ev.post_irq  = armed && !wdata[C_STB] && ctrl_q[C_IEN];
  end

  always_comb begin
    ctrl_d = ctrl_q;
    dout_d = dout_q;
    if (acc.wr_ctrl) ctrl_d = wdata | CTRL_FIXED;
    if (acc.wr_data) dout_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      dout_q <= DATA_RST;
    end else begin
      if (acc.wr_ctrl) ctrl_q <= ctrl_d;
      if (acc.wr_data) dout_q <= dout_d;
    end
  end

  assert_ctrl_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc.wr_ctrl |=> (ctrl_q == ($past(wdata) | 8'hC0)));

  assert_emit_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev.emit |=> !ev.emit);

  assert_select_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc.wr_ctrl && !wdata[C_SEL]) |-> !(ev.emit || ev.post_irq || ev.busy_clr));
endmodule

// File: rtl/ppr_status_seq.sv
module ppr_status_seq
  import ppr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  acc_t             acc,
  input  ctrl_ev_t         ev,
  input  logic             ctrl_stb,
  output logic [REG_W-1:0] stat_q,
  output logic             pend_q
);
  logic [REG_W-1:0] stat_d;
  logic             pend_d;
  logic             stat_en, pend_en;
  logic             step;

  assign step = acc.rd_stat && !stat_q[S_BSYN] && !ctrl_stb;

  always_comb begin
    stat_d = stat_q;
    if (ev.init_load) begin
      stat_d = STAT_INIT;
    end else if (ev.busy_clr) begin
      stat_d[S_BSYN] = 1'b0;
    end else if (step) begin
      if (stat_q[S_ACK]) begin
        stat_d[S_ACK] = 1'b0;
      end else begin
        stat_d[S_ACK]  = 1'b1;
        stat_d[S_BSYN] = 1'b1;
      end
    end
    stat_en = ev.init_load || ev.busy_clr || step;
  end

  always_comb begin
    pend_d  = pend_q;
    pend_en = ev.post_irq || acc.rd_stat;
    if (ev.post_irq)       pend_d = 1'b1;
    else if (acc.rd_stat)  pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= STAT_RST;
      pend_q <= 1'b0;
    end else begin
      if (stat_en) stat_q <= stat_d;
      if (pend_en) pend_q <= pend_d;
    end
  end

  assert_init_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev.init_load |=> (stat_q == 8'hD8));

  assert_irq_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc.rd_stat && !ev.post_irq) |=> !pend_q);

  assert_irq_post_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev.post_irq |=> pend_q);

  assert_ack_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc.rd_stat && !acc.wr_ctrl && !stat_q[S_BSYN] && !ctrl_stb && stat_q[S_ACK])
      |=> (!stat_q[S_ACK] && !stat_q[S_BSYN]));

  assert_ack_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc.rd_stat && !acc.wr_ctrl && !stat_q[S_BSYN] && !ctrl_stb && !stat_q[S_ACK])
      |=> (stat_q[S_ACK] && stat_q[S_BSYN]));
endmodule

// File: rtl/printer_port_regs.sv
module printer_port_regs
  import ppr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       bus_addr,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  output logic             dev_byte_valid,
  output logic [7:0]       dev_byte,
  input  logic [7:0]       dev_din,
  output logic             irq
);
  logic [1:0]       rst_sync;
  logic             rst_int_n;
  acc_t             acc;
  ctrl_ev_t         ev;
  logic [REG_W-1:0] ctrl_q, dout_q, stat_q, din_q;
  logic             pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  ppr_decode u_dec (
    .addr (bus_addr),
    .rd   (bus_rd),
    .wr   (bus_wr),
    .acc  (acc)
  );

  ppr_ctrl_path u_ctrl (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .acc    (acc),
    .wdata  (bus_wdata),
    .ctrl_q (ctrl_q),
    .dout_q (dout_q),
    .ev     (ev)
  );

  ppr_status_seq u_stat (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .acc      (acc),
    .ev       (ev),
    .ctrl_stb (ctrl_q[C_STB]),
    .stat_q   (stat_q),
    .pend_q   (pend_q)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) din_q <= DATA_RST;
    else            din_q <= dev_din;
  end

  always_comb begin
    unique case (bus_addr)
      OFF_DATA: bus_rdata = ctrl_q[C_DIR] ? din_q : dout_q;
      OFF_STAT: bus_rdata = stat_q;
      OFF_CTRL: bus_rdata = ctrl_q;
      default:  bus_rdata = OPEN_READ;
    endcase
  end

  assign dev_byte_valid = ev.emit;
  assign dev_byte       = dout_q;
  assign irq            = pend_q;

  assert_unmapped_write_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_wr && (bus_addr > OFF_CTRL || bus_addr == OFF_STAT))
      |=> ($stable(ctrl_q) && $stable(stat_q) && $stable(dout_q) && $stable(pend_q)));

  assert_irq_on_write_only_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(irq) |-> $past(bus_wr && bus_addr == OFF_CTRL));
endmodule

// File: tb/printer_port_regs_tb_top.sv
module printer_port_regs_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata, dev_byte, dev_din = 8'h00;
  logic       dev_byte_valid, irq;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] rd_q[$];
  string      rd_tag[$];
  logic [7:0] em_q[$];
  string      em_tag[$];

  always #2.5 clk = ~clk;

  printer_port_regs dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dev_byte_valid(dev_byte_valid),
    .dev_byte(dev_byte), .dev_din(dev_din), .irq(irq)
  );

  // monitor: read data and emitted bytes, compared at the falling edge
  always @(negedge clk) begin
    if (bus_rd) begin
      checks++;
      if (rd_q.size() == 0) begin
        errors++; $display("FAIL unexpected read: got %02h expected none", bus_rdata);
      end else begin
        logic [7:0] e; string t;
        e = rd_q.pop_front(); t = rd_tag.pop_front();
        if (bus_rdata !== e) begin
          errors++; $display("FAIL %s: read got %02h expected %02h", t, bus_rdata, e);
        end
      end
    end
    if (dev_byte_valid) begin
      checks++;
      if (em_q.size() == 0) begin
        errors++; $display("FAIL R5 R10: unexpected emit got %02h expected none", dev_byte);
      end else begin
        logic [7:0] e; string t;
        e = em_q.pop_front(); t = em_tag.pop_front();
        if (dev_byte !== e) begin
          errors++; $display("FAIL %s: emit got %02h expected %02h", t, dev_byte, e);
        end
      end
    end
  end

  task automatic acc_wr(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic acc_rd(input logic [2:0] a, input logic [7:0] e, input string t);
    rd_q.push_back(e); rd_tag.push_back(t);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic expect_emit(input logic [7:0] e, input string t);
    em_q.push_back(e); em_tag.push_back(t);
  endtask

  task automatic chk_irq(input logic e, input string t);
    checks++;
    if (irq !== e) begin
      errors++; $display("FAIL %s: irq got %0b expected %0b", t, irq, e);
    end
  endtask

  task automatic idle();
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R1 reset state
    chk_irq(1'b0, "R1 irq");
    acc_rd(3'd0, 8'hFF, "R1 data");
    acc_rd(3'd1, 8'hD9, "R1 status");
    acc_rd(3'd2, 8'hCC, "R1 control");
    acc_rd(3'd5, 8'hFF, "R2 open offset");
    // R9 output-mode data read
    acc_wr(3'd0, 8'h5A);
    acc_rd(3'd0, 8'h5A, "R9 out mode");
    // R2 ignored writes
    acc_wr(3'd1, 8'h00);
    acc_wr(3'd3, 8'h00);
    acc_wr(3'd7, 8'h00);
    acc_rd(3'd1, 8'hD9, "R2 status kept");
    acc_rd(3'd2, 8'hCC, "R2 control kept");
    acc_rd(3'd0, 8'h5A, "R2 data kept");
    // R3, R4
    acc_wr(3'd2, 8'h00);
    acc_rd(3'd2, 8'hC0, "R3 fixed bits");
    acc_rd(3'd1, 8'hD8, "R4 init load");
    // R6: enable only in new value posts nothing
    acc_wr(3'd2, 8'h1C);
    chk_irq(1'b0, "R6 enable not yet stored");
    // R5: strobe rising emits and clears busy
    expect_emit(8'h5A, "R5 strobe edge");
    acc_wr(3'd2, 8'h0D);
    chk_irq(1'b0, "R6 strobe high no irq");
    acc_wr(3'd2, 8'h0D);
    acc_rd(3'd2, 8'hCD, "R3 readback");
    acc_wr(3'd2, 8'h1C);
    chk_irq(1'b0, "R6 prior enable clear");
    // R8 handshake walk
    acc_rd(3'd1, 8'h58, "R5 busy cleared");
    acc_rd(3'd1, 8'h18, "R8 ack dropped");
    acc_rd(3'd1, 8'hD8, "R8 ack and busy set");
    acc_rd(3'd1, 8'hD8, "R8 hold while busy");
    // R6 / R7
    acc_wr(3'd2, 8'h1C);
    chk_irq(1'b1, "R6 irq posted");
    acc_rd(3'd1, 8'hD8, "R7 status on clear");
    chk_irq(1'b0, "R7 irq cleared");
    // R10 select low
    acc_wr(3'd2, 8'h15);
    acc_rd(3'd1, 8'hD8, "R10 busy untouched");
    acc_wr(3'd2, 8'h14);
    chk_irq(1'b0, "R10 no irq");
    // R4 after a busy clear
    expect_emit(8'h5A, "R5 second edge");
    acc_wr(3'd2, 8'h0D);
    acc_wr(3'd2, 8'h08);
    acc_rd(3'd1, 8'hD8, "R4 reload after clear");
    // R9 input mode
    dev_din = 8'h3C;
    acc_wr(3'd2, 8'h2C);
    acc_rd(3'd0, 8'h3C, "R9 input byte");
    dev_din = 8'hA5;
    idle();
    acc_rd(3'd0, 8'hA5, "R9 input byte change");
    acc_rd(3'd2, 8'hEC, "R3 direction stored");
    idle();
    checks++;
    if (em_q.size() != 0 || rd_q.size() != 0) begin
      errors++;
      $display("FAIL R5: pending items got %0d expected 0", em_q.size() + rd_q.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule